// File: doc/BRIEF.md
# DDS Parameter Source Priority Selector

This block sits in front of a direct digital synthesis core. On every clock it decides, separately for the frequency tuning word, the phase offset word and the amplitude scale factor, which source supplies the value. There are four candidate sources: a waveform RAM output, a digital ramp generator output, a parallel data port added to a base tuning word, and a bank of eight single-tone profiles selected by a 3-bit profile input. Each source has its own enable and its own destination code. A source only claims a parameter when it is enabled and its destination names that parameter. Any parameter that no higher source claims falls back to the single-tone value.

The eight profile registers are shared between single-tone use and RAM use. A single RAM mode bit decides what they hold. While RAM mode is active, the bank holds RAM configuration words, and the single-tone fallback comes from a separate set of base words. Single-tone writes made during RAM mode go to a shadow copy, which is loaded back into the bank when RAM mode ends. RAM configuration writes made during single-tone mode are kept in the same way until RAM mode starts.

When nothing is driving the output, the block raises a power-down flag and forces the amplitude to zero. All selected words are registered once before they leave the block.

Top module: `dds_param_select`

## Requirements
- R1: The frequency word comes from the first of these that applies, in this order: RAM (RAM mode on and RAM destination frequency), ramp generator (enabled with destination frequency), parallel port (enabled with destination frequency), single-tone fallback. Destination codes: 0 frequency, 1 phase, 2 amplitude, 3 polar.
- R2: A source that is enabled but has another destination does not take the parameter. The parameter then goes to the next source in priority, ending at the single-tone fallback of the active profile.
- R3: Phase and amplitude follow the same priority. RAM with phase or polar destination supplies phase from bits 31:16 of its word. RAM with amplitude destination supplies amplitude from bits 31:18. RAM with polar destination supplies amplitude from bits 15:2. The ramp generator supplies phase from bits 31:16 and amplitude from bits 31:18. A ramp destination of 3 claims nothing.
- R4: A change of profile select appears at the outputs exactly one clock edge after the edge that samples it.
- R5: While RAM mode is off, the single-tone fallback is the active profile's word and the RAM configuration output is zero. While RAM mode is on, the fallback is the base words and the RAM configuration output is the active profile's RAM configuration.
- R6: A single-tone write made while RAM mode is on leaves the RAM configuration output unchanged. The written value becomes the fallback after RAM mode turns off.
- R7: A RAM configuration write made while RAM mode is off leaves every output unchanged. It appears on the RAM configuration output once RAM mode turns on.
- R8: The parallel port supplies three things. Frequency is the base tuning word plus the 16-bit port value shifted left by 16. Phase is the port value itself. Amplitude is port bits 15:2.
- R9: When tone enable, RAM mode, ramp enable and port enable are all off, the power-down flag is 1 and the amplitude is 0. Otherwise the flag is 0.
- R10: During and right after reset, all words are zero and the power-down flag is 1. Profiles, shadows and base words reset to zero, and RAM mode is off.
- R11: A change of the RAM enable input takes effect on the outputs two edges after the edge that samples it. Profile words are packed with the tuning word in bits 61:30, phase in 29:14 and amplitude in 13:0. Write kinds: 0 single-tone, 1 RAM configuration, 2 base words (address ignored).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prof_sel | input | 3 | Active profile select |
| ram_en | input | 1 | RAM mode request |
| ram_dst | input | 2 | RAM destination code |
| ram_data | input | 32 | RAM playback word |
| drg_en | input | 1 | Ramp generator enable |
| drg_dst | input | 2 | Ramp generator destination code |
| drg_data | input | 32 | Ramp generator word |
| pdp_en | input | 1 | Parallel port enable |
| pdp_dst | input | 2 | Parallel port destination code |
| pdp_data | input | 16 | Parallel port value |
| tone_en | input | 1 | Single-tone output enable |
| wr_en | input | 1 | Storage write strobe |
| wr_kind | input | 2 | Write target kind |
| wr_addr | input | 3 | Profile index for the write |
| wr_data | input | 62 | Packed profile word |
| ftw_o | output | 32 | Selected frequency tuning word |
| pow_o | output | 16 | Selected phase offset word |
| asf_o | output | 14 | Selected amplitude scale factor |
| pwrdn_o | output | 1 | Power-down flag |
| ram_cfg_o | output | 62 | Active profile RAM configuration |

## Verification
A corrupted profile or shadow entry shows up only when its profile is selected and no higher source claims the parameter. It appears on the fallback word one edge after the select reaches it, or after the mode swap for a shadow. For that reason the sweep visits every profile under every combination of enables and destinations in both modes. A wrong RAM mode bit changes which fallback set and which configuration output are used, and this is visible two edges after the enable toggles. A priority or slicing fault shows on the first cycle with that combination of enables.

// File: rtl/dps_pkg.sv
package dps_pkg;
    localparam int FTW_W = 32;
    localparam int POW_W = 16;
    localparam int ASF_W = 14;
    localparam int PDP_W = 16;

    typedef enum logic [1:0] {
        DST_FREQ  = 2'd0,
        DST_PHASE = 2'd1,
        DST_AMPL  = 2'd2,
        DST_POLAR = 2'd3
    } dst_e;

    typedef enum logic [1:0] {
        WK_TONE = 2'd0,
        WK_RAMC = 2'd1,
        WK_BASE = 2'd2,
        WK_NONE = 2'd3
    } wr_kind_e;

    typedef struct packed {
        logic [FTW_W-1:0] ftw;
        logic [POW_W-1:0] pow;
        logic [ASF_W-1:0] asf;
    } prof_t;

    localparam int PROF_W = $bits(prof_t);
endpackage

// File: rtl/dps_prof_bank.sv
module dps_prof_bank
    import dps_pkg::*;
#(
    parameter int NPROF = 8,
    localparam int AW = $clog2(NPROF)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ram_en,
    input  logic            wr_en,
    input  logic [1:0]      wr_kind,
    input  logic [AW-1:0]   wr_addr,
    input  prof_t           wr_data,
    input  logic [AW-1:0]   prof_sel,
    output logic            ram_mode,
    output prof_t           act_prof,
    output prof_t           base
);
    typedef struct packed {
        logic                   ram_mode;
        prof_t [NPROF-1:0]      bank;
        prof_t [NPROF-1:0]      tone_sh;
        prof_t [NPROF-1:0]      ram_sh;
        prof_t                  base;
    } bank_st_t;

    bank_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.ram_mode = ram_en;
        if (wr_en) begin
            case (wr_kind_e'(wr_kind))
                WK_TONE: begin
                    s_d.tone_sh[wr_addr] = wr_data;
                    if (!s_q.ram_mode) s_d.bank[wr_addr] = wr_data;
                end
                WK_RAMC: begin
                    s_d.ram_sh[wr_addr] = wr_data;
                    if (s_q.ram_mode) s_d.bank[wr_addr] = wr_data;
                end
                WK_BASE: s_d.base = wr_data;
                default: ;
            endcase
        end
        // mode swap repurposes the whole bank from the matching shadow
        if (ram_en && !s_q.ram_mode)
            s_d.bank = s_d.ram_sh;
        else if (!ram_en && s_q.ram_mode)
            s_d.bank = s_d.tone_sh;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ram_mode = s_q.ram_mode;
    assign act_prof = s_q.bank[prof_sel];
    assign base     = s_q.base;
endmodule

// File: rtl/dps_param_arb.sv
module dps_param_arb
    import dps_pkg::*;
(
    input  logic              ram_mode,
    input  logic [1:0]        ram_dst,
    input  logic [FTW_W-1:0]  ram_data,
    input  logic              drg_en,
    input  logic [1:0]        drg_dst,
    input  logic [FTW_W-1:0]  drg_data,
    input  logic              pdp_en,
    input  logic [1:0]        pdp_dst,
    input  logic [PDP_W-1:0]  pdp_data,
    input  logic              tone_en,
    input  prof_t             act_prof,
    input  prof_t             base,
    output logic [FTW_W-1:0]  ftw,
    output logic [POW_W-1:0]  pow,
    output logic [ASF_W-1:0]  asf,
    output logic              pwrdn,
    output prof_t             ram_cfg
);
    localparam int PSH = FTW_W - PDP_W;
    localparam int POLAR_TOP = FTW_W - POW_W - 1;

    prof_t fb;
    logic  ram_f, ram_p, ram_a, ram_pol, drg_f, drg_p, drg_a, pdp_f, pdp_p, pdp_a;

    always_comb begin
        fb      = ram_mode ? base : act_prof;
        ram_f   = ram_mode && (dst_e'(ram_dst) == DST_FREQ);
        ram_pol = ram_mode && (dst_e'(ram_dst) == DST_POLAR);
        ram_p   = ram_mode && ((dst_e'(ram_dst) == DST_PHASE) || ram_pol);
        ram_a   = ram_mode && (dst_e'(ram_dst) == DST_AMPL);
        drg_f   = drg_en && (dst_e'(drg_dst) == DST_FREQ);
        drg_p   = drg_en && (dst_e'(drg_dst) == DST_PHASE);
        drg_a   = drg_en && (dst_e'(drg_dst) == DST_AMPL);
        pdp_f   = pdp_en && (dst_e'(pdp_dst) == DST_FREQ);
        pdp_p   = pdp_en && (dst_e'(pdp_dst) == DST_PHASE);
        pdp_a   = pdp_en && (dst_e'(pdp_dst) == DST_AMPL);

        if (ram_f)      ftw = ram_data;
        else if (drg_f) ftw = drg_data;
        else if (pdp_f) ftw = base.ftw + {pdp_data, {PSH{1'b0}}};
        else            ftw = fb.ftw;

        if (ram_p)      pow = ram_data[FTW_W-1 -: POW_W];
        else if (drg_p) pow = drg_data[FTW_W-1 -: POW_W];
        else if (pdp_p) pow = pdp_data[PDP_W-1 -: POW_W];
        else            pow = fb.pow;

        pwrdn = !(tone_en || ram_mode || drg_en || pdp_en);

        if (pwrdn)        asf = '0;
        else if (ram_a)   asf = ram_data[FTW_W-1 -: ASF_W];
        else if (ram_pol) asf = ram_data[POLAR_TOP -: ASF_W];
        else if (drg_a)   asf = drg_data[FTW_W-1 -: ASF_W];
        else if (pdp_a)   asf = pdp_data[PDP_W-1 -: ASF_W];
        else              asf = fb.asf;

        ram_cfg = ram_mode ? act_prof : '0;
    end
endmodule

// File: rtl/dds_param_select.sv
module dds_param_select
    import dps_pkg::*;
#(
    parameter int NPROF = 8,
    localparam int AW = $clog2(NPROF)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     prof_sel,
    input  logic              ram_en,
    input  logic [1:0]        ram_dst,
    input  logic [FTW_W-1:0]  ram_data,
    input  logic              drg_en,
    input  logic [1:0]        drg_dst,
    input  logic [FTW_W-1:0]  drg_data,
    input  logic              pdp_en,
    input  logic [1:0]        pdp_dst,
    input  logic [PDP_W-1:0]  pdp_data,
    input  logic              tone_en,
    input  logic              wr_en,
    input  logic [1:0]        wr_kind,
    input  logic [AW-1:0]     wr_addr,
    input  logic [PROF_W-1:0] wr_data,
    output logic [FTW_W-1:0]  ftw_o,
    output logic [POW_W-1:0]  pow_o,
    output logic [ASF_W-1:0]  asf_o,
    output logic              pwrdn_o,
    output logic [PROF_W-1:0] ram_cfg_o
);
    typedef struct packed {
        logic [FTW_W-1:0] ftw;
        logic [POW_W-1:0] pow;
        logic [ASF_W-1:0] asf;
        logic             pwrdn;
        prof_t            ram_cfg;
    } out_st_t;

    logic  ram_mode;
    prof_t act_prof, base, sel_cfg;
    logic [FTW_W-1:0] sel_ftw;
    logic [POW_W-1:0] sel_pow;
    logic [ASF_W-1:0] sel_asf;
    logic             sel_pwrdn;
    out_st_t o_d, o_q;

    dps_prof_bank #(.NPROF(NPROF)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .ram_en   (ram_en),
        .wr_en    (wr_en),
        .wr_kind  (wr_kind),
        .wr_addr  (wr_addr),
        .wr_data  (prof_t'(wr_data)),
        .prof_sel (prof_sel),
        .ram_mode (ram_mode),
        .act_prof (act_prof),
        .base     (base)
    );

    dps_param_arb u_arb (
        .ram_mode (ram_mode),
        .ram_dst  (ram_dst),
        .ram_data (ram_data),
        .drg_en   (drg_en),
        .drg_dst  (drg_dst),
        .drg_data (drg_data),
        .pdp_en   (pdp_en),
        .pdp_dst  (pdp_dst),
        .pdp_data (pdp_data),
        .tone_en  (tone_en),
        .act_prof (act_prof),
        .base     (base),
        .ftw      (sel_ftw),
        .pow      (sel_pow),
        .asf      (sel_asf),
        .pwrdn    (sel_pwrdn),
        .ram_cfg  (sel_cfg)
    );

    always_comb begin
        o_d.ftw     = sel_ftw;
        o_d.pow     = sel_pow;
        o_d.asf     = sel_asf;
        o_d.pwrdn   = sel_pwrdn;
        o_d.ram_cfg = sel_cfg;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q       <= '0;
            o_q.pwrdn <= 1'b1;
        end else begin
            o_q <= o_d;
        end
    end

    assign ftw_o     = o_q.ftw;
    assign pow_o     = o_q.pow;
    assign asf_o     = o_q.asf;
    assign pwrdn_o   = o_q.pwrdn;
    assign ram_cfg_o = o_q.ram_cfg;
endmodule

// File: rtl/dps_checker.sv
module dps_checker
    import dps_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ram_mode,
    input logic [1:0]        ram_dst,
    input logic [FTW_W-1:0]  ram_data,
    input logic              drg_en,
    input logic [1:0]        drg_dst,
    input logic [FTW_W-1:0]  drg_data,
    input logic              pdp_en,
    input logic [1:0]        pdp_dst,
    input logic [PDP_W-1:0]  pdp_data,
    input logic              tone_en,
    input logic [FTW_W-1:0]  ftw_o,
    input logic [POW_W-1:0]  pow_o,
    input logic [ASF_W-1:0]  asf_o,
    input logic              pwrdn_o,
    input logic [PROF_W-1:0] ram_cfg_o
);
    logic past_ok;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    a_r1_ram_freq_wins: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(ram_mode && ram_dst == 2'd0) |-> ftw_o == $past(ram_data));

    a_r2_drg_freq_next: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(!(ram_mode && ram_dst == 2'd0) && drg_en && drg_dst == 2'd0)
        |-> ftw_o == $past(drg_data));

    a_r8_pdp_phase: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(!(ram_mode && ram_dst[0]) && !(drg_en && drg_dst == 2'd1)
                         && pdp_en && pdp_dst == 2'd1)
        |-> pow_o == $past(pdp_data));

    a_r9_pd_zero_amp: assert property (@(posedge clk) disable iff (!rst_n)
        pwrdn_o |-> asf_o == '0);

    a_r9_pd_cause: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> pwrdn_o == $past(!(tone_en || ram_mode || drg_en || pdp_en)));

    a_r5_cfg_zero_in_tone: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(!ram_mode) |-> ram_cfg_o == '0);
endmodule

bind dds_param_select dps_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ram_mode  (ram_mode),
    .ram_dst   (ram_dst),
    .ram_data  (ram_data),
    .drg_en    (drg_en),
    .drg_dst   (drg_dst),
    .drg_data  (drg_data),
    .pdp_en    (pdp_en),
    .pdp_dst   (pdp_dst),
    .pdp_data  (pdp_data),
    .tone_en   (tone_en),
    .ftw_o     (ftw_o),
    .pow_o     (pow_o),
    .asf_o     (asf_o),
    .pwrdn_o   (pwrdn_o),
    .ram_cfg_o (ram_cfg_o)
);

// File: tb/dds_param_select_tb.sv
module dds_param_select_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  prof_sel = '0;
    logic        ram_en = 1'b0;
    logic [1:0]  ram_dst = '0;
    logic [31:0] ram_data = '0;
    logic        drg_en = 1'b0;
    logic [1:0]  drg_dst = '0;
    logic [31:0] drg_data = '0;
    logic        pdp_en = 1'b0;
    logic [1:0]  pdp_dst = '0;
    logic [15:0] pdp_data = '0;
    logic        tone_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_kind = '0;
    logic [2:0]  wr_addr = '0;
    logic [61:0] wr_data = '0;
    logic [31:0] ftw_o;
    logic [15:0] pow_o;
    logic [13:0] asf_o;
    logic        pwrdn_o;
    logic [61:0] ram_cfg_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // reference storage, fields packed ftw[61:30] pow[29:14] asf[13:0]
    logic [61:0] tone_m [8];
    logic [61:0] ramc_m [8];
    logic [61:0] base_m = '0;
    logic        mode_m = 1'b0;

    dds_param_select u_dut (
        .clk(clk), .rst_n(rst_n), .prof_sel(prof_sel), .ram_en(ram_en),
        .ram_dst(ram_dst), .ram_data(ram_data), .drg_en(drg_en), .drg_dst(drg_dst),
        .drg_data(drg_data), .pdp_en(pdp_en), .pdp_dst(pdp_dst), .pdp_data(pdp_data),
        .tone_en(tone_en), .wr_en(wr_en), .wr_kind(wr_kind), .wr_addr(wr_addr),
        .wr_data(wr_data), .ftw_o(ftw_o), .pow_o(pow_o), .asf_o(asf_o),
        .pwrdn_o(pwrdn_o), .ram_cfg_o(ram_cfg_o)
    );

    always #10 clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [1:0] kind, input logic [2:0] a, input logic [61:0] d);
        wr_en = 1'b1; wr_kind = kind; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
        if (kind == 2'd0) tone_m[a] = d;
        else if (kind == 2'd1) ramc_m[a] = d;
        else if (kind == 2'd2) base_m = d;
    endtask

    // expected outputs from the requirement text, given current inputs
    task automatic check_all(input string ctx);
        logic [61:0] fb;
        logic [31:0] ef;
        logic [15:0] ep;
        logic [13:0] ea;
        logic        epd;
        fb = mode_m ? base_m : tone_m[prof_sel];
        if (mode_m && ram_dst == 2'd0)       ef = ram_data;
        else if (drg_en && drg_dst == 2'd0)  ef = drg_data;
        else if (pdp_en && pdp_dst == 2'd0)  ef = base_m[61:30] + {pdp_data, 16'h0};
        else                                 ef = fb[61:30];
        if (mode_m && (ram_dst == 2'd1 || ram_dst == 2'd3)) ep = ram_data[31:16];
        else if (drg_en && drg_dst == 2'd1)  ep = drg_data[31:16];
        else if (pdp_en && pdp_dst == 2'd1)  ep = pdp_data;
        else                                 ep = fb[29:14];
        epd = !(tone_en || mode_m || drg_en || pdp_en);
        if (epd)                             ea = '0;
        else if (mode_m && ram_dst == 2'd2)  ea = ram_data[31:18];
        else if (mode_m && ram_dst == 2'd3)  ea = ram_data[15:2];
        else if (drg_en && drg_dst == 2'd2)  ea = drg_data[31:18];
        else if (pdp_en && pdp_dst == 2'd2)  ea = pdp_data[15:2];
        else                                 ea = fb[13:0];
        tick();
        chk({"R1/R2 freq ", ctx}, 64'(ftw_o), 64'(ef));
        chk({"R3/R8 phase ", ctx}, 64'(pow_o), 64'(ep));
        chk({"R3 ampl ", ctx}, 64'(asf_o), 64'(ea));
        chk({"R9 pwrdn ", ctx}, 64'(pwrdn_o), 64'(epd));
        chk({"R5 ramcfg ", ctx}, 64'(ram_cfg_o), 64'(mode_m ? ramc_m[prof_sel] : 62'h0));
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin tone_m[i] = '0; ramc_m[i] = '0; end
        tick(); tick();
        // R10: reset state
        chk("R10 ftw", 64'(ftw_o), 64'h0);
        chk("R10 pow", 64'(pow_o), 64'h0);
        chk("R10 asf", 64'(asf_o), 64'h0);
        chk("R10 pwrdn", 64'(pwrdn_o), 64'h1);
        chk("R10 cfg", 64'(ram_cfg_o), 64'h0);
        rst_n = 1'b1;
        tick();
        chk("R10 profile zero after reset", 64'(ftw_o), 64'h0);

        for (int i = 0; i < 8; i++)
            wr(2'd0, 3'(i), {32'h0100_0000 * (i + 1) + 32'(i), 16'h1111 * 16'(i + 1),
                             14'(14'h0123 * (i + 1))});
        wr(2'd2, 3'd5, {32'h0040_0000, 16'h0ABC, 14'h1F00});
        tone_en = 1'b1;
        prof_sel = 3'd6;
        check_all("pre-ramcfg");
        // R7: RAM configuration writes in tone mode leave outputs alone
        for (int i = 0; i < 8; i++)
            wr(2'd1, 3'(i), {32'hA000_0000 | 32'(i), 16'hC000 | 16'(i), 14'h0200 | 14'(i)});
        tick();
        chk("R7 ftw unchanged", 64'(ftw_o), 64'(tone_m[6][61:30]));
        chk("R7 cfg still zero", 64'(ram_cfg_o), 64'h0);

        // R1 R2 R3 R5 R8 R9: sweep every profile, enable and destination in both modes
        for (int rm = 0; rm < 2; rm++) begin
            ram_en = rm[0];
            tick(); tick();
            mode_m = rm[0];
            for (int p = 0; p < 8; p++)
                for (int en = 0; en < 8; en++)
                    for (int d = 0; d < 64; d++) begin
                        int idx;
                        idx = ((rm * 8 + p) * 8 + en) * 64 + d;
                        prof_sel = 3'(p);
                        tone_en  = en[0];
                        drg_en   = en[1];
                        pdp_en   = en[2];
                        ram_dst  = d[1:0];
                        drg_dst  = d[3:2];
                        pdp_dst  = d[5:4];
                        ram_data = 32'h9E37_79B9 * 32'(idx + 1);
                        drg_data = ~ram_data ^ 32'h5A5A_0F0F;
                        pdp_data = 16'(idx * 1009 + 7);
                        check_all("sweep");
                    end
        end

        // R4: profile change lands exactly one edge later
        ram_en = 1'b0; tone_en = 1'b1; drg_en = 1'b0; pdp_en = 1'b0;
        tick(); tick(); mode_m = 1'b0;
        prof_sel = 3'd2; tick();
        prof_sel = 3'd5;
        #2;
        chk("R4 old profile before edge", 64'(ftw_o), 64'(tone_m[2][61:30]));
        tick();
        chk("R4 new profile after one edge", 64'(ftw_o), 64'(tone_m[5][61:30]));

        // R11: RAM enable toggle reaches outputs after two edges
        prof_sel = 3'd4; tick();
        ram_en = 1'b1; tick();
        chk("R11 still tone after one edge", 64'(ftw_o), 64'(tone_m[4][61:30]));
        tick();
        mode_m = 1'b1;
        chk("R11 base fallback after two edges", 64'(ftw_o), 64'(base_m[61:30]));
        chk("R11 ram cfg after two edges", 64'(ram_cfg_o), 64'(ramc_m[4]));

        // R6: tone write during RAM mode goes to shadow only
        wr(2'd0, 3'd4, {32'h7777_1234, 16'h4321, 14'h0ABC});
        tick();
        chk("R6 ram cfg untouched", 64'(ram_cfg_o), 64'(ramc_m[4]));
        chk("R6 fallback still base", 64'(ftw_o), 64'(base_m[61:30]));
        ram_en = 1'b0; tick(); tick();
        mode_m = 1'b0;
        chk("R6 shadow applied ftw", 64'(ftw_o), 64'h7777_1234);
        chk("R6 shadow applied pow", 64'(pow_o), 64'h4321);
        chk("R6 shadow applied asf", 64'(asf_o), 64'h0ABC);
        chk("R6 cfg zero in tone", 64'(ram_cfg_o), 64'h0);

        // R9: nothing enabled
        tone_en = 1'b0; tick(); tick();
        chk("R9 pwrdn set", 64'(pwrdn_o), 64'h1);
        chk("R9 amplitude zero", 64'(asf_o), 64'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule